// File: doc/BRIEF.md
# Serial Pin Expander Controller

This block adds general-purpose pins to a chip by shifting them over four wires: a serial clock, a data-out line, a data-in line and a load strobe. External shift registers (not part of this block) sit on the other end of the wires. Up to 32 ports can take part, and each port carries the same number of bits, from 1 to 4. The system clock is divided down to form the serial clock.

A burst walks through every enabled port in ascending order and through the bits of each port. For every bit it drives a value chosen by a 3-bit source code and samples the returning input. The burst then ends with a load slot, and an optional idle gap follows. Inputs are stored transposed: one readable word per bit index, with one bit per port. Bursts either repeat without a break (auto-repeat) or run once on a self-clearing trigger. Software reads and writes a small register file through a one-cycle write strobe and a registered read port.

Top module: `sgx_expander`

## Requirements
- R1: After synchronous reset, ser_clk_o, ser_dout_o and ser_load_o are low, every register reads 0, and no burst runs.
- R2: Register map. Address 0 is control: bit 0 auto-repeat, bit 1 single-shot, bits [3:2] bits-per-port minus one, bits [15:8] gap length. Address 1 is the divider in bits [11:0]. Address 2 is the port-enable mask, bit P for port P. Addresses 4..7 are input words, read only. Address 32+P holds port P's source codes, with bit b at [3b+2:3b]. Any other address reads 0. bus_rdata shows the addressed register one cycle after bus_addr is presented.
- R3: A slot lasts D = max(2, divider) system cycles. D is taken while the block is idle and held for as long as bursts run. The serial clock is low for the first floor(D/2) cycles of a shift slot and high for the rest.
- R4: Shift slots cover the enabled ports in ascending order and bits 0 up to width within each port. Disabled ports take no time.
- R5: Source code 1 drives the data-out line high for the slot. Codes 0 and 2..7 drive it low.
- R6: After the last shift slot comes one load slot with ser_load_o high and the serial clock and data-out low.
- R7: After the load slot come gap x D idle cycles with all three outputs low. A gap of 0 adds no idle cycles.
- R8: With auto-repeat set, a new burst begins in the cycle after the previous one ends.
- R9: Setting single-shot while idle starts one burst. The bit clears when a burst ends with auto-repeat off. With auto-repeat on it stays set.
- R10: The data-in line is sampled on the system edge at which the serial clock rises. At the end of the load slot, the sample for port P bit b becomes bit P of input word 4+b. Positions not shifted keep their earlier value.
- R11: With an empty port mask, a burst consists only of the load slot and the gap.
- R12: All serial outputs are registered and follow the sequencer state with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ser_clk_o | output | 1 | Serial clock |
| ser_dout_o | output | 1 | Serial data to the external shift chain |
| ser_din_i | input | 1 | Serial data from the external input chain |
| ser_load_o | output | 1 | Load strobe that ends each burst |

## Verification
The hardest case to reach is the single-shot bit under auto-repeat. Seen from the ports, a bit that never clears looks exactly like a bit that clears late. The stimulus therefore sets both bits, lets several bursts pass, and reads the control word back mid-run. It then drops auto-repeat during a running burst and checks that the bit clears exactly at that burst's end. A cycle-level reference model runs beside the design and covers the dense cases: a sparse port mask that includes port 31, an odd divider, a zero divider and an empty mask.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_GAP   = 2'd3
  } seq_st_t;

  localparam int SRC_W     = 3;
  localparam int A_CTRL    = 0;
  localparam int A_DIV     = 1;
  localparam int A_MASK    = 2;
  localparam int A_IN_BASE = 4;
  localparam logic [SRC_W-1:0] SRC_HIGH = 3'd1;
endpackage

// File: rtl/sgx_tick.sv
module sgx_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             slot_end,
  output logic             rise,
  output logic             high
);
  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] dq;
  logic [DIV_W-1:0] div_eff;

  assign div_eff  = (div_val < DIV_W'(2)) ? DIV_W'(2) : div_val;
  assign slot_end = run && (pc == dq - 1'b1);
  assign rise     = run && (pc == (dq >> 1));
  assign high     = run && (pc >= (dq >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      dq <= DIV_W'(2);
    end else if (!run) begin
      pc <= '0;
      dq <= div_eff;
    end else if (slot_end) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // R3
  pc_range_chk: assert property (@(posedge clk) disable iff (rst) pc < dq);
  // R3
  div_floor_chk: assert property (@(posedge clk) disable iff (rst) dq >= DIV_W'(2));
endmodule

// File: rtl/sgx_regs.sv
module sgx_regs
  import sgx_pkg::*;
#(
  parameter int NPORTS = 32,
  parameter int MAXB   = 4,
  parameter int DIV_W  = 12,
  parameter int GAP_W  = 8,
  parameter int DATA_W = 32,
  localparam int PW    = $clog2(NPORTS),
  localparam int BW    = (MAXB > 1) ? $clog2(MAXB) : 1,
  localparam int AW    = PW + 1,
  localparam int CFG_W = SRC_W * MAXB
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rpt_en,
  output logic                   one_shot,
  output logic [BW-1:0]          width_m1,
  output logic [GAP_W-1:0]       gap_len,
  output logic [DIV_W-1:0]       div_val,
  output logic [NPORTS-1:0]      port_mask,
  input  logic [PW-1:0]          src_port,
  input  logic [BW-1:0]          src_bit,
  output logic [SRC_W-1:0]       src_code,
  input  logic                   clr_shot,
  input  logic [MAXB*NPORTS-1:0] in_flat
);
  logic [CFG_W-1:0]  cfg_mem [NPORTS];
  logic [DATA_W-1:0] rd_mux;
  logic              ctrl_hit;
  int                row;

  assign ctrl_hit = we && (addr == AW'(A_CTRL));
  assign row      = int'(addr) - A_IN_BASE;
  assign src_code = cfg_mem[src_port][SRC_W*int'(src_bit) +: SRC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_en    <= 1'b0;
      one_shot  <= 1'b0;
      width_m1  <= '0;
      gap_len   <= '0;
      div_val   <= '0;
      port_mask <= '0;
      for (int i = 0; i < NPORTS; i++) cfg_mem[i] <= '0;
    end else begin
      if (ctrl_hit) begin
        rpt_en   <= wdata[0];
        width_m1 <= wdata[2 +: BW];
        gap_len  <= wdata[8 +: GAP_W];
      end
      if (ctrl_hit)      one_shot <= wdata[1];
      else if (clr_shot) one_shot <= 1'b0;
      if (we && addr == AW'(A_DIV))  div_val   <= wdata[DIV_W-1:0];
      if (we && addr == AW'(A_MASK)) port_mask <= wdata[NPORTS-1:0];
      if (we && addr[AW-1])          cfg_mem[addr[PW-1:0]] <= wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr[AW-1]) begin
      rd_mux[CFG_W-1:0] = cfg_mem[addr[PW-1:0]];
    end else if (row >= 0 && row < MAXB) begin
      rd_mux[NPORTS-1:0] = in_flat[row*NPORTS +: NPORTS];
    end else if (addr == AW'(A_CTRL)) begin
      rd_mux[0]          = rpt_en;
      rd_mux[1]          = one_shot;
      rd_mux[2 +: BW]    = width_m1;
      rd_mux[8 +: GAP_W] = gap_len;
    end else if (addr == AW'(A_DIV)) begin
      rd_mux[DIV_W-1:0] = div_val;
    end else if (addr == AW'(A_MASK)) begin
      rd_mux[NPORTS-1:0] = port_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  wire unused_wdata = ^wdata;

  // R9
  shot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(one_shot) && !$past(ctrl_hit)) |-> !$past(rpt_en));
endmodule

// File: rtl/sgx_seq.sv
module sgx_seq
  import sgx_pkg::*;
#(
  parameter int NPORTS = 32,
  parameter int MAXB   = 4,
  parameter int GAP_W  = 8,
  localparam int PW    = $clog2(NPORTS),
  localparam int BW    = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rpt_en,
  input  logic                   one_shot,
  input  logic [BW-1:0]          width_m1,
  input  logic [GAP_W-1:0]       gap_len,
  input  logic [NPORTS-1:0]      port_mask,
  input  logic                   din,
  input  logic                   slot_end,
  input  logic                   rise,
  input  logic                   high,
  input  logic [SRC_W-1:0]       src_code,
  output logic                   run,
  output logic [PW-1:0]          port_q,
  output logic [BW-1:0]          bit_q,
  output logic                   clr_shot,
  output logic [MAXB*NPORTS-1:0] in_flat,
  output logic                   sclk_o,
  output logic                   dout_o,
  output logic                   load_o
);
  seq_st_t            st, st_n;
  logic [PW-1:0]      port_n;
  logic [BW-1:0]      bit_n;
  logic [GAP_W-1:0]   gcnt, gcnt_n;
  logic               go, burst_end;
  logic [PW:0]        nx, fs;
  logic [MAXB*NPORTS-1:0] stage;

  function automatic logic [PW:0] first_from(input logic [NPORTS-1:0] m,
                                             input logic [PW:0] from);
    logic [PW:0] r;
    r = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (i >= int'(from) && m[i]) r = {1'b1, PW'(i)};
    return r;
  endfunction

  assign run = (st != ST_IDLE);
  assign nx  = first_from(port_mask, (PW+1)'(port_q) + 1'b1);
  assign fs  = first_from(port_mask, '0);

  always_comb begin
    st_n      = st;
    port_n    = port_q;
    bit_n     = bit_q;
    gcnt_n    = gcnt;
    go        = 1'b0;
    burst_end = 1'b0;
    clr_shot  = 1'b0;
    case (st)
      ST_IDLE: go = rpt_en || one_shot;
      ST_SHIFT:
        if (slot_end) begin
          if (bit_q < width_m1) bit_n = bit_q + 1'b1;
          else if (nx[PW]) begin
            port_n = nx[PW-1:0];
            bit_n  = '0;
          end else st_n = ST_LOAD;
        end
      ST_LOAD:
        if (slot_end) begin
          if (gap_len == '0) burst_end = 1'b1;
          else begin
            st_n   = ST_GAP;
            gcnt_n = '0;
          end
        end
      default:
        if (slot_end) begin
          if (gcnt == gap_len - 1'b1) burst_end = 1'b1;
          else gcnt_n = gcnt + 1'b1;
        end
    endcase
    if (burst_end) begin
      if (rpt_en) go = 1'b1;
      else begin
        st_n     = ST_IDLE;
        clr_shot = 1'b1;
      end
    end
    if (go) begin
      bit_n = '0;
      if (fs[PW]) begin
        st_n   = ST_SHIFT;
        port_n = fs[PW-1:0];
      end else st_n = ST_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      port_q  <= '0;
      bit_q   <= '0;
      gcnt    <= '0;
      stage   <= '0;
      in_flat <= '0;
      sclk_o  <= 1'b0;
      dout_o  <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      st     <= st_n;
      port_q <= port_n;
      bit_q  <= bit_n;
      gcnt   <= gcnt_n;
      if (st == ST_SHIFT && rise)
        stage[int'(bit_q)*NPORTS + int'(port_q)] <= din;
      if (st == ST_LOAD && slot_end) in_flat <= stage;
      sclk_o <= (st == ST_SHIFT) && high;
      dout_o <= (st == ST_SHIFT) && (src_code == SRC_HIGH);
      load_o <= (st == ST_LOAD);
    end
  end

  // R6
  load_excl_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |-> (!sclk_o && !dout_o));
  // R10
  in_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_flat != $past(in_flat)) |-> $past(load_o));
endmodule

// File: rtl/sgx_expander.sv
module sgx_expander
  import sgx_pkg::*;
#(
  parameter int NPORTS = 32,
  parameter int MAXB   = 4,
  parameter int DIV_W  = 12,
  parameter int GAP_W  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NPORTS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_clk_o,
  output logic              ser_dout_o,
  input  logic              ser_din_i,
  output logic              ser_load_o
);
  localparam int PW = $clog2(NPORTS);
  localparam int BW = (MAXB > 1) ? $clog2(MAXB) : 1;

  logic                   rpt_en, one_shot, clr_shot, run;
  logic                   slot_end, rise, high;
  logic [BW-1:0]          width_m1, bit_q;
  logic [GAP_W-1:0]       gap_len;
  logic [DIV_W-1:0]       div_val;
  logic [NPORTS-1:0]      port_mask;
  logic [PW-1:0]          port_q;
  logic [SRC_W-1:0]       src_code;
  logic [MAXB*NPORTS-1:0] in_flat;

  sgx_regs #(.NPORTS(NPORTS), .MAXB(MAXB), .DIV_W(DIV_W), .GAP_W(GAP_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .rpt_en(rpt_en), .one_shot(one_shot), .width_m1(width_m1), .gap_len(gap_len),
    .div_val(div_val), .port_mask(port_mask), .src_port(port_q), .src_bit(bit_q),
    .src_code(src_code), .clr_shot(clr_shot), .in_flat(in_flat)
  );

  sgx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div_val(div_val),
    .slot_end(slot_end), .rise(rise), .high(high)
  );

  sgx_seq #(.NPORTS(NPORTS), .MAXB(MAXB), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst(rst), .rpt_en(rpt_en), .one_shot(one_shot), .width_m1(width_m1),
    .gap_len(gap_len), .port_mask(port_mask), .din(ser_din_i), .slot_end(slot_end),
    .rise(rise), .high(high), .src_code(src_code), .run(run), .port_q(port_q),
    .bit_q(bit_q), .clr_shot(clr_shot), .in_flat(in_flat), .sclk_o(ser_clk_o),
    .dout_o(ser_dout_o), .load_o(ser_load_o)
  );
endmodule

// File: tb/sim_sgx_expander.sv
module sim_sgx_expander;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1, we = 1'b0, din = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, dout, load;

  sgx_expander u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .ser_clk_o(sclk), .ser_dout_o(dout), .ser_din_i(din),
    .ser_load_o(load)
  );

  always #(CLK_P/2) clk = ~clk;

  int    errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_st, m_pc, m_dq, m_port, m_bit, m_gc, m_wid, m_gap, m_div;
  bit          m_rep, m_os;
  logic [31:0] m_mask;
  int          m_cfg[32];
  logic [31:0] m_stg[4], m_in[4];
  bit          e_sclk, e_dout, e_load;
  logic [31:0] e_rd;

  function automatic int first_en(input logic [31:0] m, input int from);
    for (int i = from; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] rdval(input int a);
    if (a == 0) return 32'(m_rep) | (32'(m_os) << 1) | (32'(m_wid) << 2) | (32'(m_gap) << 8);
    if (a == 1) return 32'(m_div);
    if (a == 2) return m_mask;
    if (a >= 4 && a < 8) return m_in[a-4];
    if (a >= 32) return 32'(m_cfg[a-32]);
    return 32'd0;
  endfunction

  always @(posedge clk) begin : model
    int st0, nx;
    bit go, bend, clr, sdone;
    if (rst) begin
      m_st = 0; m_pc = 0; m_dq = 2; m_port = 0; m_bit = 0; m_gc = 0;
      m_wid = 0; m_gap = 0; m_div = 0; m_rep = 0; m_os = 0; m_mask = 0;
      for (int i = 0; i < 32; i++) m_cfg[i] = 0;
      for (int i = 0; i < 4; i++) begin m_stg[i] = 0; m_in[i] = 0; end
      e_sclk = 0; e_dout = 0; e_load = 0; e_rd = 0;
    end else begin
      st0 = m_st; go = 0; bend = 0; clr = 0;
      e_rd   = rdval(int'(addr));
      e_sclk = (m_st == 1) && (m_pc >= m_dq / 2);
      e_dout = (m_st == 1) && (((m_cfg[m_port] >> (3 * m_bit)) & 7) == 1);
      e_load = (m_st == 2);
      if (m_st == 1 && m_pc == m_dq / 2) m_stg[m_bit][m_port] = din;
      sdone = (m_st != 0) && (m_pc == m_dq - 1);
      if (m_st == 0) go = m_rep || m_os;
      else if (m_st == 1 && sdone) begin
        if (m_bit < m_wid) m_bit++;
        else begin
          nx = first_en(m_mask, m_port + 1);
          if (nx >= 0) begin m_port = nx; m_bit = 0; end
          else m_st = 2;
        end
      end else if (m_st == 2 && sdone) begin
        for (int i = 0; i < 4; i++) m_in[i] = m_stg[i];
        if (m_gap == 0) bend = 1; else begin m_st = 3; m_gc = 0; end
      end else if (m_st == 3 && sdone) begin
        if (m_gc == m_gap - 1) bend = 1; else m_gc++;
      end
      if (bend) begin
        if (m_rep) go = 1; else begin m_st = 0; clr = 1; end
      end
      if (go) begin
        nx = first_en(m_mask, 0);
        m_bit = 0;
        if (nx >= 0) begin m_st = 1; m_port = nx; end else m_st = 2;
      end
      if (st0 == 0) begin m_pc = 0; m_dq = (m_div < 2) ? 2 : m_div; end
      else if (m_pc == m_dq - 1) m_pc = 0;
      else m_pc++;
      if (we && addr == 0) begin
        m_rep = wdata[0]; m_os = wdata[1]; m_wid = int'(wdata[3:2]); m_gap = int'(wdata[15:8]);
      end else if (clr) m_os = 0;
      if (we && addr == 1) m_div = int'(wdata[11:0]);
      if (we && addr == 2) m_mask = wdata;
      if (we && addr >= 32) m_cfg[int'(addr) - 32] = int'(wdata[11:0]);
    end
  end

  // per-cycle comparison, port monitor, input stimulus
  logic [15:0] lfsr = 16'hACE1;
  bit          p_sclk = 0, p_load = 0;
  int          rise_cyc[$];
  bit          rise_dout[$], rise_din[$];
  int          load_hi = 0, load_rise = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(sclk == e_sclk, (cur_req == "R1") ? "R12" : cur_req, "ser_clk", sclk, e_sclk);
      chk(dout == e_dout, (cur_req == "R1") ? "R5" : cur_req, "ser_dout", dout, e_dout);
      chk(load == e_load, (cur_req == "R1") ? "R6" : cur_req, "ser_load", load, e_load);
      chk(rdata == e_rd, "R2", "rdata", rdata, e_rd);
      if (sclk && !p_sclk) begin
        rise_cyc.push_back(cyc); rise_dout.push_back(dout); rise_din.push_back(din);
      end
      if (load) load_hi++;
      if (load && !p_load) load_rise++;
      p_sclk = sclk; p_load = load;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    din  = lfsr[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr = 6'(a);
    @(negedge clk); v = rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (m_st != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_mon();
    rise_cyc.delete(); rise_dout.delete(); rise_din.delete();
    load_hi = 0; load_rise = 0;
  endtask

  initial begin
    logic [31:0] v, e4, e5;
    bit exp_seq[6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!sclk && !dout && !load, "R1", "outputs after reset", {sclk, dout, load}, 0);
    rd(0, v); chk(v == 0, "R1", "control after reset", v, 0);
    rd(2, v); chk(v == 0, "R1", "mask after reset", v, 0);

    // R4 / R5 sparse mask including port 31, divider 4, two bits per port, one shot
    cur_req = "R4";
    wr(32, 32'd1); wr(35, 32'd8); wr(63, 32'd13);
    wr(2, 32'h8000_0009); wr(1, 32'd4);
    rd(1, v); chk(v == 4, "R2", "divider readback", v, 4);
    rd(63, v); chk(v == 13, "R2", "port 31 config readback", v, 13);
    clear_mon();
    wr(0, 32'h0000_0206);
    wait_idle();
    chk(rise_cyc.size() == 6, "R4", "clock rises in burst", rise_cyc.size(), 6);
    for (int k = 0; k < 6 && k < rise_dout.size(); k++)
      chk(rise_dout[k] == exp_seq[k], "R5", "data-out at rise", rise_dout[k], exp_seq[k]);
    if (rise_cyc.size() >= 2)
      chk(rise_cyc[1] - rise_cyc[0] == 4, "R3", "rise spacing div 4", rise_cyc[1] - rise_cyc[0], 4);
    chk(load_hi == 4, "R6", "load slot length", load_hi, 4);
    rd(0, v); chk(v == 32'h204, "R9", "single-shot cleared", v, 32'h204);
    if (rise_din.size() == 6) begin
      e4 = 32'(rise_din[0]) | (32'(rise_din[2]) << 3) | (32'(rise_din[4]) << 31);
      e5 = 32'(rise_din[1]) | (32'(rise_din[3]) << 3) | (32'(rise_din[5]) << 31);
      rd(4, v); chk(v == e4, "R10", "input word bit 0", v, e4);
      rd(5, v); chk(v == e5, "R10", "input word bit 1", v, e5);
    end

    // R8 / R9 auto-repeat with single-shot set, divider 0 -> 2, four bits
    cur_req = "R8";
    wr(1, 32'd0); wr(2, 32'h0000_0081);
    clear_mon();
    wr(0, 32'h0000_010F);
    repeat (70) @(negedge clk);
    chk(load_rise >= 3, "R8", "back-to-back bursts", load_rise, 3);
    if (rise_cyc.size() >= 2)
      chk(rise_cyc[1] - rise_cyc[0] == 2, "R3", "rise spacing div floor", rise_cyc[1] - rise_cyc[0], 2);
    rd(0, v); chk(v == 32'h10F, "R9", "single-shot held under repeat", v, 32'h10F);
    wr(0, 32'h0000_010E);
    wait_idle();
    rd(0, v); chk(v == 32'h10C, "R9", "single-shot cleared after repeat off", v, 32'h10C);

    // R11 / R7 empty mask, gap 3, divider 3
    cur_req = "R7";
    wr(2, 32'd0); wr(1, 32'd3);
    clear_mon();
    wr(0, 32'h0000_0302);
    wait_idle();
    chk(rise_cyc.size() == 0, "R11", "no clock with empty mask", rise_cyc.size(), 0);
    chk(load_hi == 3, "R11", "load only burst", load_hi, 3);

    // R8 / R10 all ports, odd divider, no gap, repeat
    cur_req = "R3";
    wr(2, 32'hFFFF_FFFF); wr(1, 32'd5);
    clear_mon();
    wr(0, 32'h0000_0001);
    repeat (400) @(negedge clk);
    chk(load_rise >= 2, "R8", "repeat with zero gap", load_rise, 2);
    wr(0, 32'h0000_0000);
    wait_idle();
    rd(4, v); chk(v == m_in[0], "R10", "full input word", v, m_in[0]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule